// File: doc/BRIEF.md
# Multi-format serial audio receiver

This block turns a three-wire stereo audio stream (bit clock, frame clock, serial data) into parallel two's-complement samples. Words arrive most significant bit first, and in every frame the left word comes before the right word. A single bit-slot engine handles five framing conventions: right-justified, I2S-style, left-justified, DSP pulse-framed, and a packed variant with 32 bit clocks per frame. The conventions differ in frame-clock polarity, in the offset of the first data bit from the slot boundary, in the bit-clock edge on which data is sampled, and in whether the frame clock is a level or a pulse.

A free-running system clock samples all three serial wires, so bit-clock edges are found by comparing successive samples. The format and the word length each come from two sources, a pair of mode pins and a pair of control-register bits. The two sources are combined by OR, and the unused source must be tied to zero. Completed words are left-aligned in 24-bit output registers. Each word is announced by a one-cycle strobe for its channel.

Top module: `audio_ser_rx`

## Requirements
- R1: The format code is `modePins | modeReg`: 0 right-justified, 1 I2S-style, 2 left-justified, 3 DSP. The length code is `lenPins | lenReg`: 0 means 16 bits, 1 means 18, 2 means 20, 3 means 24.
- R2: A received word of L bits is placed MSB-first in bits 23 down to 24-L of the channel output, and the low 24-L bits read zero.
- R3: Right-justified mode samples on rising bit-clock edges. Frame clock high marks left and low marks right. Within a slot, the sample taken on the first rising edge after a frame-clock change is index 0. The MSB is at index 16, and the word is always 16 bits whatever the length code.
- R4: I2S-style mode samples on rising edges. Frame clock low marks left and high marks right. The MSB is at slot index 1.
- R5: Left-justified mode samples on rising edges. Frame clock high marks left. The MSB is at slot index 0.
- R6: DSP mode samples on falling bit-clock edges. The MSB is the first bit sampled with the frame clock low after it was sampled high. The first such pulse after reset starts a left word, and channels alternate from then on.
- R7: When `packedEn` is 1 with right- or left-justified format, each slot carries a 16-bit word starting at index 0 (32 bit clocks per frame). With I2S-style or DSP format, `packedEn` has no effect.
- R8: Bits sampled after the last bit of the word, before the MSB offset, or before the first frame boundary after reset do not change the output word.
- R9: Each completed word raises exactly one one-cycle strobe on its channel (`leftValid` or `rightValid`), and the two strobes never coincide.
- R10: While `rstN` is low, both outputs read zero and both strobes are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the serial wires |
| rstN | input | 1 | Active-low asynchronous reset |
| bitClk | input | 1 | Serial bit clock |
| frameClk | input | 1 | Frame clock (level or pulse, depending on format) |
| serData | input | 1 | Serial data, MSB first |
| modePins | input | 2 | Format code from pins |
| modeReg | input | 2 | Format code from control register |
| lenPins | input | 2 | Word-length code from pins |
| lenReg | input | 2 | Word-length code from control register |
| packedEn | input | 1 | Selects 32-bit-clock packed framing |
| leftData | output | 24 | Last left word, left-aligned |
| leftValid | output | 1 | One-cycle strobe for a new left word |
| rightData | output | 24 | Last right word, left-aligned |
| rightValid | output | 1 | One-cycle strobe for a new right word |

## Verification
The embedded properties check the following on every cycle:
- Strobe exclusivity and one-cycle width.
- Zero fill below the active word length whenever a strobe is raised.
- That a strobe always follows a bit load.
- That right-justified and packed captures never write beyond bit 16.
- The reset values.

Only the bench's sweeps can show that the captured bits actually come from the right slot index and bit-clock edge for each format and word length, and that the channel polarity is correct. The same holds for the OR-combination of pin and register codes, for DSP left/right alternation from the first pulse, and for junk bits outside the data window being ignored.

// File: rtl/audio_ser_rx_pkg.sv
package audio_ser_rx_pkg;

  localparam int WORD_W = 24;
  localparam int POS_W  = $clog2(WORD_W);

  typedef enum logic [1:0] {
    FMT_RJ  = 2'd0,
    FMT_I2S = 2'd1,
    FMT_LJ  = 2'd2,
    FMT_DSP = 2'd3
  } fmt_e;

  // strobes from the slot controller to the word datapath
  typedef struct packed {
    logic             clear;
    logic             load;
    logic [POS_W-1:0] pos;
    logic             bitVal;
    logic             doneL;
    logic             doneR;
  } dpCtl_t;

endpackage

// File: rtl/audio_ser_rx_ctrl.sv
module audio_ser_rx_ctrl
  import audio_ser_rx_pkg::*;
#(
  parameter int RJ_DELAY  = 16,
  parameter int SHORT_LEN = 16,
  parameter int IDX_W     = 6
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             bitClk,
  input  logic             frameClk,
  input  logic             serData,
  input  fmt_e             fmt,
  input  logic [1:0]       lenCode,
  input  logic             packedEn,
  output dpCtl_t           ctl,
  output logic [IDX_W-1:0] effLen
);

  localparam logic [IDX_W-1:0] IDX_MAX = {IDX_W{1'b1}};

  logic bcQ, fcQ, sdQ, bcPrev;
  logic fcLast, fcSeen, synced, chanRight, dspAny, slotDone;
  logic doneLQ, doneRQ;
  logic [IDX_W-1:0] bitIdx;

  logic riseEv, fallEv, isDsp, sampleEv, packedMode;
  logic levelEdge, dspStart, slotStart, newRight, curRight, live, take, lastBit;
  logic [IDX_W-1:0] msbDelay, curIdx, bitNo;

  function automatic logic [IDX_W-1:0] lenOf(input logic [1:0] code);
    case (code)
      2'd0:    lenOf = IDX_W'(16);
      2'd1:    lenOf = IDX_W'(18);
      2'd2:    lenOf = IDX_W'(20);
      default: lenOf = IDX_W'(24);
    endcase
  endfunction

  always_comb begin
    riseEv     = bcQ & ~bcPrev;
    fallEv     = ~bcQ & bcPrev;
    isDsp      = (fmt == FMT_DSP);
    sampleEv   = isDsp ? fallEv : riseEv;
    packedMode = packedEn && (fmt == FMT_RJ || fmt == FMT_LJ);

    if (packedMode || fmt == FMT_RJ) effLen = IDX_W'(SHORT_LEN);
    else                             effLen = lenOf(lenCode);

    if (packedMode)          msbDelay = '0;
    else if (fmt == FMT_RJ)  msbDelay = IDX_W'(RJ_DELAY);
    else if (fmt == FMT_I2S) msbDelay = IDX_W'(1);
    else                     msbDelay = '0;

    levelEdge = sampleEv && fcSeen && !isDsp && (fcQ != fcLast);
    dspStart  = sampleEv && fcSeen && isDsp && fcLast && !fcQ;
    slotStart = levelEdge || dspStart;

    if (isDsp)               newRight = dspAny ? ~chanRight : 1'b0;
    else if (fmt == FMT_I2S) newRight = fcQ;
    else                     newRight = ~fcQ;

    curIdx   = slotStart ? '0 : bitIdx;
    curRight = slotStart ? newRight : chanRight;
    live     = sampleEv && (slotStart || (synced && !slotDone));
    bitNo    = curIdx - msbDelay;
    take     = live && (curIdx >= msbDelay) && (bitNo < effLen);
    lastBit  = take && (bitNo == effLen - IDX_W'(1));

    ctl.clear  = slotStart;
    ctl.load   = take;
    ctl.pos    = bitNo[POS_W-1:0];
    ctl.bitVal = sdQ;
    ctl.doneL  = doneLQ;
    ctl.doneR  = doneRQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bcQ <= 1'b0; fcQ <= 1'b0; sdQ <= 1'b0; bcPrev <= 1'b0;
      fcLast <= 1'b0; fcSeen <= 1'b0; synced <= 1'b0;
      chanRight <= 1'b0; dspAny <= 1'b0; slotDone <= 1'b0;
      bitIdx <= '0; doneLQ <= 1'b0; doneRQ <= 1'b0;
    end else begin
      bcQ    <= bitClk;
      fcQ    <= frameClk;
      sdQ    <= serData;
      bcPrev <= bcQ;
      if (sampleEv) begin
        fcLast <= fcQ;
        fcSeen <= 1'b1;
      end
      if (slotStart) begin
        synced    <= 1'b1;
        chanRight <= newRight;
        bitIdx    <= IDX_W'(1);
        slotDone  <= 1'b0;
        if (isDsp) dspAny <= 1'b1;
      end else if (sampleEv && bitIdx != IDX_MAX) begin
        bitIdx <= bitIdx + IDX_W'(1);
      end
      if (lastBit) slotDone <= 1'b1;
      doneLQ <= lastBit && !curRight;
      doneRQ <= lastBit && curRight;
    end
  end

  // R3: right-justified words never use more than the fixed short width
  assert_rj_width_R3: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.load && fmt == FMT_RJ) |-> (ctl.pos < POS_W'(SHORT_LEN)));

  // R7: packed slots never write beyond the short width
  assert_packed_width_R7: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.load && packedMode) |-> (ctl.pos < POS_W'(SHORT_LEN)));

  // R9: a completion strobe is always preceded by a bit load
  assert_done_after_load_R9: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.doneL || ctl.doneR) |-> $past(ctl.load));

endmodule

// File: rtl/audio_ser_rx_dpath.sv
module audio_ser_rx_dpath
  import audio_ser_rx_pkg::*;
#(
  parameter int IDX_W = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtl_t            ctl,
  input  logic [IDX_W-1:0]  effLen,
  output logic [WORD_W-1:0] leftData,
  output logic [WORD_W-1:0] rightData,
  output logic              leftValid,
  output logic              rightValid
);

  localparam logic [WORD_W-1:0] FULL = {WORD_W{1'b1}};

  logic [WORD_W-1:0] acc, accNext;
  logic [POS_W-1:0]  bitSlot;

  always_comb begin
    bitSlot = POS_W'(WORD_W - 1) - ctl.pos;
    accNext = ctl.clear ? '0 : acc;
    if (ctl.load) accNext[bitSlot] = ctl.bitVal;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      acc        <= '0;
      leftData   <= '0;
      rightData  <= '0;
      leftValid  <= 1'b0;
      rightValid <= 1'b0;
    end else begin
      acc        <= accNext;
      leftValid  <= ctl.doneL;
      rightValid <= ctl.doneR;
      if (ctl.doneL) leftData  <= acc;
      if (ctl.doneR) rightData <= acc;
    end
  end

  // R9: strobes are exclusive and last one cycle
  assert_strobe_excl_R9: assert property (@(posedge clk) disable iff (!rstN)
    !(leftValid && rightValid));
  assert_strobe_pulse_R9: assert property (@(posedge clk) disable iff (!rstN)
    (leftValid |=> !leftValid) and (rightValid |=> !rightValid));

  // R2: bits below the active word length read zero when a word is announced
  assert_zero_fill_R2: assert property (@(posedge clk) disable iff (!rstN)
    (leftValid |-> ((leftData & (FULL >> effLen)) == '0)) and
    (rightValid |-> ((rightData & (FULL >> effLen)) == '0)));

  // R10: reset clears outputs and strobes
  assert_reset_state_R10: assert property (@(posedge clk)
    !rstN |=> (!leftValid && !rightValid && leftData == '0 && rightData == '0));

endmodule

// File: rtl/audio_ser_rx.sv
module audio_ser_rx
  import audio_ser_rx_pkg::*;
#(
  parameter int RJ_DELAY  = 16,
  parameter int SHORT_LEN = 16,
  parameter int IDX_W     = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              bitClk,
  input  logic              frameClk,
  input  logic              serData,
  input  logic [1:0]        modePins,
  input  logic [1:0]        modeReg,
  input  logic [1:0]        lenPins,
  input  logic [1:0]        lenReg,
  input  logic              packedEn,
  output logic [WORD_W-1:0] leftData,
  output logic              leftValid,
  output logic [WORD_W-1:0] rightData,
  output logic              rightValid
);

  fmt_e             fmt;
  logic [1:0]       lenCode;
  dpCtl_t           ctl;
  logic [IDX_W-1:0] effLen;

  // R1: both sources have equal weight
  assign fmt     = fmt_e'(modePins | modeReg);
  assign lenCode = lenPins | lenReg;

  audio_ser_rx_ctrl #(
    .RJ_DELAY(RJ_DELAY), .SHORT_LEN(SHORT_LEN), .IDX_W(IDX_W)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .bitClk(bitClk), .frameClk(frameClk),
    .serData(serData), .fmt(fmt), .lenCode(lenCode), .packedEn(packedEn),
    .ctl(ctl), .effLen(effLen)
  );

  audio_ser_rx_dpath #(.IDX_W(IDX_W)) dpath_i (
    .clk(clk), .rstN(rstN), .ctl(ctl), .effLen(effLen),
    .leftData(leftData), .rightData(rightData),
    .leftValid(leftValid), .rightValid(rightValid)
  );

endmodule

// File: tb/audio_ser_rx_tb_top.sv
`timescale 1ns/1ps
module audio_ser_rx_tb_top;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic bitClk = 1'b0, frameClk = 1'b0, serData = 1'b0;
  logic [1:0] modePins = '0, modeReg = '0, lenPins = '0, lenReg = '0;
  logic packedEn = 1'b0;
  logic [23:0] leftData, rightData;
  logic leftValid, rightValid;

  int total = 0;
  int bad = 0;
  int lCnt = 0, rCnt = 0;
  logic [23:0] lGot [2];
  logic [23:0] rGot [2];

  always #2.5 clk = ~clk;

  audio_ser_rx dut_i (
    .clk(clk), .rstN(rstN), .bitClk(bitClk), .frameClk(frameClk),
    .serData(serData), .modePins(modePins), .modeReg(modeReg),
    .lenPins(lenPins), .lenReg(lenReg), .packedEn(packedEn),
    .leftData(leftData), .leftValid(leftValid),
    .rightData(rightData), .rightValid(rightValid)
  );

  always @(negedge clk) begin
    if (leftValid) begin
      if (lCnt < 2) lGot[lCnt] = leftData;
      lCnt++;
    end
    if (rightValid) begin
      if (rCnt < 2) rGot[rCnt] = rightData;
      rCnt++;
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic sendBit(input logic fc, input logic d);
    frameClk = fc;
    serData  = d;
    repeat (4) @(negedge clk);
    bitClk = 1'b1;
    repeat (4) @(negedge clk);
    bitClk = 1'b0;
  endtask

  task automatic runCfg(input int fmt, input int lc, input bit pk, input int cfgIdx);
    int effL, delay, slotLen, src;
    bit isDsp, packedMode;
    logic [23:0] base, mask;
    logic [23:0] words [4];
    logic [23:0] w;
    logic lvl;
    string tag;

    isDsp      = (fmt == 3);
    packedMode = pk && (fmt == 0 || fmt == 2);
    effL       = (fmt == 0 || packedMode) ? 16 : (lc == 0 ? 16 : lc == 1 ? 18 : lc == 2 ? 20 : 24);
    delay      = packedMode ? 0 : (fmt == 0 ? 16 : fmt == 1 ? 1 : 0);
    slotLen    = packedMode ? 16 : 32;
    mask       = 24'hFFFFFF << (24 - effL);
    src        = cfgIdx % 3;
    case (fmt)
      0: tag = packedMode ? "R7/R3" : "R3";
      1: tag = pk ? "R4/R7" : "R4";
      2: tag = packedMode ? "R7/R5" : "R5";
      default: tag = pk ? "R6/R7" : "R6";
    endcase

    base = 24'hC5A3E1 ^ (24'(cfgIdx) * 24'h0913B7);
    words[0] = base;
    words[1] = ~base;
    words[2] = {base[11:0], base[23:12]};
    words[3] = base ^ 24'h800001;

    rstN = 1'b0;
    bitClk = 1'b0; frameClk = 1'b0; serData = 1'b0;
    packedEn = pk;
    case (src)
      0: begin modePins = 2'(fmt); modeReg = '0; lenPins = 2'(lc); lenReg = '0; end
      1: begin modePins = '0; modeReg = 2'(fmt); lenPins = '0; lenReg = 2'(lc); end
      default: begin
        modePins = 2'(fmt) & 2'b01; modeReg = 2'(fmt) & 2'b10;
        lenPins  = 2'(lc) & 2'b01;  lenReg  = 2'(lc) & 2'b10;
      end
    endcase
    repeat (5) @(negedge clk);
    lCnt = 0; rCnt = 0;
    // R10: reset state
    check(leftData == '0 && rightData == '0 && !leftValid && !rightValid,
          "R10 reset", {leftData[15:0], rightData[15:0]}, 32'd0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);

    // preamble at right-channel level (or idle low for DSP), junk data: R8
    lvl = isDsp ? 1'b0 : (fmt == 1 ? 1'b1 : 1'b0);
    for (int i = 0; i < 4; i++) sendBit(lvl, 1'b1);

    for (int f = 0; f < 2; f++) begin
      for (int ch = 0; ch < 2; ch++) begin
        w = words[2*f + ch];
        if (isDsp) begin
          sendBit(1'b1, 1'b1);
          for (int i = 0; i < 31; i++) sendBit(1'b0, (i < effL) ? w[23-i] : 1'b1);
        end else begin
          lvl = (fmt == 1) ? 1'(ch) : ~1'(ch);
          for (int i = 0; i < slotLen; i++) begin
            int k;
            k = i - delay;
            sendBit(lvl, (k >= 0 && k < effL) ? w[23-k] : 1'b1);
          end
        end
      end
    end
    for (int i = 0; i < 3; i++) sendBit(isDsp ? 1'b0 : lvl, 1'b1);
    repeat (4) @(negedge clk);

    // R9: one strobe per word per channel
    check(lCnt == 2, {"R9 left strobes ", tag}, 32'(lCnt), 32'd2);
    check(rCnt == 2, {"R9 right strobes ", tag}, 32'(rCnt), 32'd2);
    // R1 R2 R8: word content, alignment, zero fill, junk ignored
    check(lGot[0] == (words[0] & mask), {"R1/R2/R8 left f0 ", tag}, 32'(lGot[0]), 32'(words[0] & mask));
    check(rGot[0] == (words[1] & mask), {"R1/R2/R8 right f0 ", tag}, 32'(rGot[0]), 32'(words[1] & mask));
    check(lGot[1] == (words[2] & mask), {"R2/R8 left f1 ", tag}, 32'(lGot[1]), 32'(words[2] & mask));
    check(rGot[1] == (words[3] & mask), {"R2/R8 right f1 ", tag}, 32'(rGot[1]), 32'(words[3] & mask));
  endtask

  initial begin
    int idx;
    idx = 0;
    for (int fmt = 0; fmt < 4; fmt++)
      for (int lc = 0; lc < 4; lc++)
        for (int pk = 0; pk < 2; pk++) begin
          runCfg(fmt, lc, 1'(pk), idx);
          idx++;
        end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule